// File: doc/BRIEF.md
# Reloadable Down-Counting Interrupt Timer

This block is a down-counter with a configurable width, driven by a small register port that writes on the clock edge and reads without a wait state. Software writes a start value. The counter then counts down by one on each pulse of the tick-enable input that the control register selects. Two tick inputs come in from outside: a fast one and a slow one. When the counter underflows it either reloads the start value (periodic mode) or rolls over to its all-ones value (free-running mode). In both modes it raises a level interrupt.

The interrupt stays asserted until software writes any value to the clear register. A typical use is a periodic system tick or a one-shot event timer. In the one-shot case, software clears the control word, writes a new start value and enables the counter again.

The register port takes a word index: 0 selects the start value, 1 the live count, 2 the control word and 3 the interrupt clear. These correspond to byte offsets 0x00, 0x04, 0x08 and 0x0C.

Top module: `reload_timer`

## Requirements
- R1: After reset the live count, start value and control word all read 0, and `irq` is low.
- R2: A write to word 0 stores `bus_wdata[CNT_W-1:0]` as the start value and also copies it into the counter. Both registers read back zero-extended to 32 bits.
- R3: While control bit 7 (enable) is 0, the count does not change. Writing 0 to the control word stops a running counter.
- R4: Control bit 3 selects `tick_fast` when it is 1 and `tick_slow` when it is 0. The unselected tick input has no effect on the count.
- R5: On a selected tick with the counter enabled and a nonzero count, the count decreases by exactly one.
- R6: With control bit 6 set to 1 (periodic), a selected tick at count 0 reloads the count from the start value.
- R7: With control bit 6 set to 0 (free-running), a selected tick at count 0 wraps the count to all ones.
- R8: A selected tick at count 0 raises `irq` on the next cycle. `irq` then stays high until a clear write.
- R9: A write of any data to word 3 drops `irq` on the next cycle. If an underflow occurs in the same cycle, `irq` stays high.
- R10: Reads of the control word return only bits 7, 6 and 3; all other bits read 0. Reads of word 3 return 0.
- R11: A start-value write in the same cycle as a selected tick takes priority. The count becomes the written value, with no decrement and no underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word index: 0 start value, 1 live count, 2 control, 3 interrupt clear |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_fast | input | 1 | Fast-rate count enable pulse |
| tick_slow | input | 1 | Slow-rate count enable pulse |
| irq | output | 1 | Level interrupt, set on underflow |

## Verification
The hardest case to reach is a cycle in which three things coincide: the count is already zero, a selected tick arrives, and software writes the clear register. This is the only cycle where setting and clearing the interrupt compete. A close second is a start-value write that lands on a tick.

The stimulus first runs the counter down to zero one pulse at a time, using tasks that leave one idle cycle after each pulse. It then drives a single cycle that carries both the tick and the register write. The behavioural model, compared on every clock, confirms that both the interrupt and the count came out right.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BUS_W         = 32;
    localparam int CTRL_EN_BIT   = 7;
    localparam int CTRL_PER_BIT  = 6;
    localparam int CTRL_FAST_BIT = 3;

    typedef enum logic [1:0] {
        SEL_START = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_CLEAR = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic enable;
        logic periodic;
        logic fast;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [BUS_W-1:0] w);
        ctrl_t c;
        c.enable   = w[CTRL_EN_BIT];
        c.periodic = w[CTRL_PER_BIT];
        c.fast     = w[CTRL_FAST_BIT];
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] ctrl_pack(input ctrl_t c);
        logic [BUS_W-1:0] w;
        w = '0;
        w[CTRL_EN_BIT]   = c.enable;
        w[CTRL_PER_BIT]  = c.periodic;
        w[CTRL_FAST_BIT] = c.fast;
        return w;
    endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [CNT_W-1:0]  cnt_val,
    output logic [CNT_W-1:0]  start_val,
    output logic [CNT_W-1:0]  start_data,
    output ctrl_t             ctrl,
    output logic              start_wr,
    output logic              clear_wr,
    output logic [BUS_W-1:0]  bus_rdata
);

    reg_sel_e sel;
    logic     ctrl_wr;
    logic     unused_wdata;

    assign sel          = reg_sel_e'(bus_addr);
    assign start_wr     = bus_wr && (sel == SEL_START);
    assign ctrl_wr      = bus_wr && (sel == SEL_CTRL);
    assign clear_wr     = bus_wr && (sel == SEL_CLEAR);
    assign start_data   = bus_wdata[CNT_W-1:0];
    assign unused_wdata = ^bus_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_val <= '0;
            ctrl      <= '0;
        end else begin
            if (start_wr) start_val <= start_data;
            if (ctrl_wr)  ctrl      <= ctrl_unpack(bus_wdata);
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_START: bus_rdata = BUS_W'(start_val);
            SEL_COUNT: bus_rdata = BUS_W'(cnt_val);
            SEL_CTRL:  bus_rdata = ctrl_pack(ctrl);
            SEL_CLEAR: bus_rdata = '0;
            default:   bus_rdata = '0;
        endcase
    end

    // R10
    ctrl_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_CTRL) |-> ((bus_rdata & ~32'h0000_00C8) == '0));

    // R2
    start_store_chk: assert property (@(posedge clk) disable iff (rst)
        start_wr |=> (start_val == $past(start_data)));

endmodule

// File: rtl/tmr_tick.sv
module tmr_tick
    import tmr_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  tick_fast,
    input  logic  tick_slow,
    output logic  tick
);

    logic picked;

    assign picked = ctrl.fast ? tick_fast : tick_slow;
    assign tick   = ctrl.enable && picked;

endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             periodic,
    input  logic             start_wr,
    input  logic [CNT_W-1:0] start_data,
    input  logic [CNT_W-1:0] start_val,
    input  logic             clear_wr,
    output logic [CNT_W-1:0] cnt,
    output logic             irq
);

    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic             at_zero;
    logic             uflow;
    logic [CNT_W-1:0] wrap_val;

    assign at_zero  = (cnt == '0);
    assign uflow    = tick && !start_wr && at_zero;
    assign wrap_val = periodic ? start_val : ALL_ONES;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            irq <= 1'b0;
        end else begin
            if (start_wr)
                cnt <= start_data;
            else if (tick)
                cnt <= at_zero ? wrap_val : cnt - 1'b1;
            irq <= uflow || (irq && !clear_wr);
        end
    end

    // R2 R11
    start_copy_chk: assert property (@(posedge clk) disable iff (rst)
        start_wr |=> (cnt == $past(start_data)));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !start_wr) |=> $stable(cnt));

    // R5
    step_down_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !start_wr && !at_zero) |=> (cnt == $past(cnt) - 1'b1));

    // R6
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        (uflow && periodic) |=> (cnt == $past(start_val)));

    // R7
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (uflow && !periodic) |=> (cnt == ALL_ONES));

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !clear_wr) |=> irq);

    // R9
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clear_wr && !uflow) |=> !irq);

    // R8 R9
    irq_set_chk: assert property (@(posedge clk) disable iff (rst)
        uflow |=> irq);

endmodule

// File: rtl/reload_timer.sv
module reload_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        tick_fast,
    input  logic        tick_slow,
    output logic        irq
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] start_val;
    logic [CNT_W-1:0] start_data;
    ctrl_t            ctrl;
    logic             start_wr;
    logic             clear_wr;
    logic             tick;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .cnt_val    (cnt),
        .start_val  (start_val),
        .start_data (start_data),
        .ctrl       (ctrl),
        .start_wr   (start_wr),
        .clear_wr   (clear_wr),
        .bus_rdata  (bus_rdata)
    );

    tmr_tick u_tick (
        .ctrl      (ctrl),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow),
        .tick      (tick)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .periodic   (ctrl.periodic),
        .start_wr   (start_wr),
        .start_data (start_data),
        .start_val  (start_val),
        .clear_wr   (clear_wr),
        .cnt        (cnt),
        .irq        (irq)
    );

    // R4
    tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_fast && ctrl.fast) |-> !tick);

endmodule

// File: tb/reload_timer_tb.sv
`timescale 1ns/1ps
module reload_timer_tb;

    localparam int W = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_fast = 1'b0;
    logic        tick_slow = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    reload_timer #(.CNT_W(W)) u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_fast(tick_fast), .tick_slow(tick_slow), .irq(irq)
    );

    always #2.5 clk = ~clk;

    // behavioural reference
    logic [W-1:0] m_cnt = '0;
    logic [W-1:0] m_start = '0;
    logic         m_en = 0, m_per = 0, m_fast = 0;
    logic         m_irq = 0;

    always @(posedge clk) begin
        bit t, sw, cw, uf;
        if (rst) begin
            m_cnt = '0; m_start = '0; m_en = 0; m_per = 0; m_fast = 0; m_irq = 0;
        end else begin
            t  = m_en && (m_fast ? tick_fast : tick_slow);
            sw = bus_wr && bus_addr == 2'd0;
            cw = bus_wr && bus_addr == 2'd3;
            uf = t && !sw && m_cnt == 0;
            m_irq = uf || (m_irq && !cw);
            if (sw) m_cnt = bus_wdata[W-1:0];
            else if (t) m_cnt = (m_cnt == 0) ? (m_per ? m_start : {W{1'b1}}) : m_cnt - 1;
            if (sw) m_start = bus_wdata[W-1:0];
            if (bus_wr && bus_addr == 2'd2) begin
                m_en = bus_wdata[7]; m_per = bus_wdata[6]; m_fast = bus_wdata[3];
            end
        end
    end

    function automatic logic [31:0] model_read(input logic [1:0] a);
        case (a)
            2'd0: return 32'(m_start);
            2'd1: return 32'(m_cnt);
            2'd2: return {24'd0, m_en, m_per, 2'b00, m_fast, 3'b000};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check("MODEL irq", {31'd0, irq}, {31'd0, m_irq});
            check("MODEL rdata", bus_rdata, model_read(bus_addr));
        end
    end

    // one cycle of stimulus followed by one idle cycle
    task automatic drive(input bit wr, input logic [1:0] a, input logic [31:0] d,
                         input bit f, input bit s);
        @(posedge clk); #1;
        bus_wr = wr; bus_addr = a; bus_wdata = d; tick_fast = f; tick_slow = s;
        @(posedge clk); #1;
        bus_wr = 0; tick_fast = 0; tick_slow = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        drive(1, a, d, 0, 0);
    endtask

    task automatic fast(input int n);
        for (int i = 0; i < n; i++) drive(0, 2'd1, 0, 1, 0);
    endtask

    task automatic slow(input int n);
        for (int i = 0; i < n; i++) drive(0, 2'd1, 0, 0, 1);
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        check(tag, bus_rdata, exp);
    endtask

    task automatic irq_chk(input bit exp, input string tag);
        @(negedge clk);
        check(tag, {31'd0, irq}, {31'd0, exp});
    endtask

    initial begin
        #(5 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        rd(2'd0, 0, "R1 start reset");
        rd(2'd1, 0, "R1 count reset");
        rd(2'd2, 0, "R1 ctrl reset");
        irq_chk(0, "R1 irq reset");

        wr(2'd0, 32'd5);
        rd(2'd1, 5, "R2 count copy");
        rd(2'd0, 5, "R2 start store");
        wr(2'd0, 32'h0001_2345);
        rd(2'd1, 32'h2345, "R2 truncated count");
        wr(2'd0, 32'd5);

        wr(2'd2, 32'h40);
        slow(2); fast(2);
        rd(2'd1, 5, "R3 disabled hold");

        wr(2'd2, 32'hC8);
        slow(2);
        rd(2'd1, 5, "R4 slow ignored in fast mode");
        fast(3);
        rd(2'd1, 2, "R5 step down");
        fast(2);
        rd(2'd1, 0, "R5 reach zero");
        irq_chk(0, "R8 no irq before underflow");
        fast(1);
        rd(2'd1, 5, "R6 periodic reload");
        irq_chk(1, "R8 irq on underflow");
        repeat (4) @(posedge clk);
        irq_chk(1, "R8 irq held");

        wr(2'd3, 32'hDEAD);
        irq_chk(0, "R9 clear drops irq");

        fast(5);
        rd(2'd1, 0, "R9 setup at zero");
        drive(1, 2'd3, 32'h1, 1, 0);
        irq_chk(1, "R9 set beats clear");
        rd(2'd1, 5, "R6 reload in collision");

        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, 32'hC8, "R10 ctrl mask");
        rd(2'd3, 0, "R10 clear reads zero");

        wr(2'd3, 0);
        wr(2'd2, 32'h88);
        wr(2'd0, 32'd0);
        fast(1);
        rd(2'd1, 32'hFFFF, "R7 free-run wrap");
        irq_chk(1, "R8 irq in free-run");
        fast(1);
        rd(2'd1, 32'hFFFE, "R5 after wrap");

        drive(1, 2'd0, 32'h0100, 1, 0);
        rd(2'd1, 32'h0100, "R11 start write beats tick");

        wr(2'd2, 32'h0);
        fast(3); slow(3);
        rd(2'd1, 32'h0100, "R3 stopped by zero ctrl");

        wr(2'd2, 32'h80);
        fast(2);
        rd(2'd1, 32'h0100, "R4 fast ignored in slow mode");
        slow(2);
        rd(2'd1, 32'h00FE, "R4 slow rate counts");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule